// File: doc/BRIEF.md
# SIMT Warp Divergence Controller

This block keeps the program counter and the 32-bit active-lane mask of one warp. Between branches the surrounding pipeline advances the PC with a step request. When a branch resolves, the block receives a per-lane taken vector, the taken target, the fall-through address and the reconvergence address for that branch. If every active lane agrees, the warp moves to the single chosen address and keeps its mask. If the lanes disagree, the warp goes on down the fall-through path with only the not-taken lanes enabled. The two outstanding contexts are kept on an internal stack for later.

On a split, two entries go onto the stack. The lower entry holds the reconvergence address with the mask from before the branch. The upper entry holds the taken target with the taken lanes. Each entry also records the reconvergence address that applies once that entry is running. When the running path reaches its own reconvergence address, the top entry is popped and becomes the live context. The taken path therefore runs second, and the full mask returns when the warp reaches the join point. Each stack update occupies one cycle, and a stall output tells the pipeline to hold its requests during that cycle.

Top module: `warp_diverge_ctl`

## Requirements
- R1: After synchronous reset, `cur_pc` equals the `RESET_PC` parameter, `cur_mask` is all ones, `stall` and `ovf_err` are low and the stack is empty. The live reconvergence address resets to all ones.
- R2: A step request (`step_valid` with no `br_valid`, no stall) loads `step_pc` into `cur_pc` on the next cycle and leaves `cur_mask` unchanged.
- R3: A branch whose taken bits, ANDed with `cur_mask`, equal `cur_mask` moves `cur_pc` to `br_target_pc` on the next cycle with `cur_mask` unchanged. Taken bits of inactive lanes are ignored.
- R4: A branch whose taken bits, ANDed with `cur_mask`, are all zero moves `cur_pc` to `br_fallthru_pc` on the next cycle with `cur_mask` unchanged.
- R5: A split branch (active taken lanes neither zero nor all of `cur_mask`) sets `cur_pc` to `br_fallthru_pc` and `cur_mask` to `cur_mask & ~br_taken` on the next cycle. `stall` is high for exactly that one cycle, while the second stack entry is written.
- R6: While `stall` is high, `br_valid` and `step_valid` are ignored.
- R7: When the stack is not empty and `cur_pc` equals the live reconvergence address, `stall` is high in that same cycle. On the next cycle the top entry becomes `cur_pc`/`cur_mask`. After a split, this first pop yields the taken target and the active taken lanes.
- R8: The second pop after a split restores the reconvergence address as `cur_pc` and the pre-branch mask as `cur_mask`. The live reconvergence address reverts to the value that applied before the split.
- R9: Nested splits resolve in last-in first-out order: the inner split's paths and join complete before the outer taken path starts.
- R10: The stack holds `STACK_DEPTH` (8) entries. A push onto a full stack is dropped and sets `ovf_err`, which stays high until reset. The live context still updates as for a normal split.
- R11: Priority is pop, then branch, then step. A branch or step presented in a pop cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Non-branch advance request |
| step_pc | input | 32 | Next PC for a step |
| br_valid | input | 1 | A branch has resolved this cycle |
| br_taken | input | 32 | Per-lane taken flags |
| br_target_pc | input | 32 | Taken target address |
| br_fallthru_pc | input | 32 | Not-taken address |
| br_reconv_pc | input | 32 | Join address for this branch |
| cur_pc | output | 32 | Live warp PC |
| cur_mask | output | 32 | Live active-lane mask, bit i = lane i |
| stall | output | 1 | Stack update in progress; requests ignored |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
A step or a uniform branch is due in `cur_pc` one clock edge after the cycle in which it is presented. A split shows its fall-through context one edge later, together with one cycle of `stall`. A pop raises `stall` in the same cycle that `cur_pc` meets the live join address, and the popped context appears one edge later. The bench drives inputs just after the falling edge and advances a behavioural model on the rising edge. It then compares every output at the next falling edge, so each result is checked in the exact cycle it is due, including stalls and ignored requests.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    localparam int LANES = 32;
    localparam int PC_W  = 32;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        pc_t        pc;
        lane_mask_t mask;
        pc_t        rpc;
    } ctx_t;

    typedef enum logic [1:0] {
        BK_FALL  = 2'd0,
        BK_TAKE  = 2'd1,
        BK_SPLIT = 2'd2
    } br_kind_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_PUSH2 = 1'b1
    } ctl_state_e;

    function automatic ctx_t make_ctx(pc_t pc, lane_mask_t m, pc_t r);
        ctx_t c;
        c.pc   = pc;
        c.mask = m;
        c.rpc  = r;
        return c;
    endfunction
endpackage

// File: rtl/wdiv_branch_eval.sv
module wdiv_branch_eval
    import wdiv_pkg::*;
(
    input  lane_mask_t live_mask,
    input  lane_mask_t taken_raw,
    output br_kind_e   kind,
    output lane_mask_t taken_lanes,
    output lane_mask_t fall_lanes
);
    always_comb begin
        taken_lanes = taken_raw & live_mask;
        fall_lanes  = live_mask & ~taken_raw;
        if (taken_lanes == live_mask)
            kind = BK_TAKE;
        else if (taken_lanes == '0)
            kind = BK_FALL;
        else
            kind = BK_SPLIT;
    end
endmodule

// File: rtl/wdiv_stack.sv
module wdiv_stack
    import wdiv_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  ctx_t push_ctx,
    input  logic pop,
    output ctx_t top_ctx,
    output logic empty,
    output logic ovf_err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctx_t           mem [DEPTH];
    logic [CW-1:0]  count;
    logic           full;
    logic [IW-1:0]  wr_idx;
    logic [IW-1:0]  rd_idx;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_idx  = IW'(count);
    assign rd_idx  = IW'(count - CW'(1));
    assign top_ctx = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            ovf_err <= 1'b0;
        end else if (push) begin
            if (full)
                ovf_err <= 1'b1;
            else
                count <= count + CW'(1);
        end else if (pop && !empty) begin
            count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_idx] <= push_ctx;
    end
endmodule

// File: rtl/warp_diverge_ctl.sv
module warp_diverge_ctl
    import wdiv_pkg::*;
#(
    parameter int              STACK_DEPTH = 8,
    parameter logic [PC_W-1:0] RESET_PC    = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  logic [PC_W-1:0]  step_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target_pc,
    input  logic [PC_W-1:0]  br_fallthru_pc,
    input  logic [PC_W-1:0]  br_reconv_pc,
    output logic [PC_W-1:0]  cur_pc,
    output logic [LANES-1:0] cur_mask,
    output logic             stall,
    output logic             ovf_err
);
    ctl_state_e state;
    ctx_t       live;
    ctx_t       pend;
    ctx_t       top_ctx;
    ctx_t       push_ctx;
    logic       push;
    logic       stk_empty;
    logic       pop_hit;
    br_kind_e   kind;
    lane_mask_t taken_lanes;
    lane_mask_t fall_lanes;

    wdiv_branch_eval u_eval (
        .live_mask   (live.mask),
        .taken_raw   (br_taken),
        .kind        (kind),
        .taken_lanes (taken_lanes),
        .fall_lanes  (fall_lanes)
    );

    wdiv_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ctx (push_ctx),
        .pop      (pop_hit),
        .top_ctx  (top_ctx),
        .empty    (stk_empty),
        .ovf_err  (ovf_err)
    );

    assign pop_hit = (state == ST_RUN) && !stk_empty && (live.pc == live.rpc);
    assign stall   = (state == ST_PUSH2) || pop_hit;

    always_comb begin
        push     = 1'b0;
        push_ctx = pend;
        if (state == ST_PUSH2) begin
            push = 1'b1;
        end else if (!pop_hit && br_valid && kind == BK_SPLIT) begin
            push     = 1'b1;
            push_ctx = make_ctx(br_reconv_pc, live.mask, live.rpc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            live  <= make_ctx(RESET_PC, '1, '1);
            pend  <= '0;
        end else if (state == ST_PUSH2) begin
            state <= ST_RUN;
        end else if (pop_hit) begin
            live <= top_ctx;
        end else if (br_valid) begin
            unique case (kind)
                BK_TAKE: live.pc <= br_target_pc;
                BK_FALL: live.pc <= br_fallthru_pc;
                default: begin
                    live  <= make_ctx(br_fallthru_pc, fall_lanes, br_reconv_pc);
                    pend  <= make_ctx(br_target_pc, taken_lanes, br_reconv_pc);
                    state <= ST_PUSH2;
                end
            endcase
        end else if (step_valid) begin
            live.pc <= step_pc;
        end
    end

    assign cur_pc   = live.pc;
    assign cur_mask = live.mask;
endmodule

// File: rtl/warp_diverge_chk.sv
module warp_diverge_chk
    import wdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             step_valid,
    input logic [PC_W-1:0]  step_pc,
    input logic             br_valid,
    input logic [LANES-1:0] br_taken,
    input logic [PC_W-1:0]  br_target_pc,
    input logic [PC_W-1:0]  br_fallthru_pc,
    input logic [PC_W-1:0]  cur_pc,
    input logic [LANES-1:0] cur_mask,
    input logic             stall,
    input logic             ovf_err
);
    AST_STEP_LOADS_PC: assert property (@(posedge clk) disable iff (rst)
        (step_valid && !br_valid && !stall) |=> (cur_pc == $past(step_pc)) && $stable(cur_mask)); // R2

    AST_UNIFORM_TAKE: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !stall && ((br_taken & cur_mask) == cur_mask))
        |=> (cur_pc == $past(br_target_pc)) && $stable(cur_mask)); // R3

    AST_UNIFORM_FALL: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !stall && ((br_taken & cur_mask) == '0) && (cur_mask != '0))
        |=> (cur_pc == $past(br_fallthru_pc)) && $stable(cur_mask)); // R4

    AST_SPLIT_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !stall && ((br_taken & cur_mask) != '0) && ((br_taken & cur_mask) != cur_mask))
        |=> stall && (cur_pc == $past(br_fallthru_pc))
            && (cur_mask == ($past(cur_mask) & ~$past(br_taken)))); // R5

    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R10
endmodule

bind warp_diverge_ctl warp_diverge_chk chk_i (.*);

// File: tb/warp_diverge_ctl_tb_top.sv
module warp_diverge_ctl_tb_top;
    import wdiv_pkg::*;

    localparam int  DEPTH = 8;
    localparam pc_t RST_PC = 32'h0000_1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_valid = 1'b0;
    pc_t        step_pc = '0;
    logic       br_valid = 1'b0;
    lane_mask_t br_taken = '0;
    pc_t        br_target_pc = '0;
    pc_t        br_fallthru_pc = '0;
    pc_t        br_reconv_pc = '0;
    pc_t        cur_pc;
    lane_mask_t cur_mask;
    logic       stall;
    logic       ovf_err;

    always #10 clk = ~clk;

    warp_diverge_ctl #(.STACK_DEPTH(DEPTH), .RESET_PC(RST_PC)) dut_i (.*);

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    ctx_t m_stk[$];
    pc_t  m_pc;
    lane_mask_t m_mask;
    pc_t  m_rpc;
    bit   m_pend;
    ctx_t m_pend_ctx;
    bit   m_ovf;

    function automatic void m_push(ctx_t c);
        if (m_stk.size() < DEPTH) m_stk.push_back(c);
        else m_ovf = 1'b1;
    endfunction

    function automatic bit m_stall();
        return m_pend || (m_stk.size() > 0 && m_pc == m_rpc);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stk.delete();
            m_pc = RST_PC; m_mask = '1; m_rpc = '1; m_pend = 0; m_ovf = 0;
        end else if (m_pend) begin
            m_push(m_pend_ctx);
            m_pend = 0;
        end else if (m_stk.size() > 0 && m_pc == m_rpc) begin
            ctx_t c;
            c = m_stk.pop_back();
            m_pc = c.pc; m_mask = c.mask; m_rpc = c.rpc;
        end else if (br_valid) begin
            lane_mask_t t;
            t = br_taken & m_mask;
            if (t == m_mask) m_pc = br_target_pc;
            else if (t == '0) m_pc = br_fallthru_pc;
            else begin
                ctx_t a;
                a.pc = br_reconv_pc; a.mask = m_mask; a.rpc = m_rpc;
                m_push(a);
                m_pend_ctx.pc = br_target_pc; m_pend_ctx.mask = t; m_pend_ctx.rpc = br_reconv_pc;
                m_pend = 1;
                m_pc = br_fallthru_pc; m_mask = m_mask & ~t; m_rpc = br_reconv_pc;
            end
        end else if (step_valid) begin
            m_pc = step_pc;
        end
        chk_on = 1'b1;
    end

    task automatic check_val(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check_val("cur_pc", 64'(cur_pc), 64'(m_pc));
            check_val("cur_mask", 64'(cur_mask), 64'(m_mask));
            check_val("stall", 64'(stall), 64'(m_stall()));
            check_val("ovf_err", 64'(ovf_err), 64'(m_ovf));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic step(pc_t p);
        @(negedge clk);
        step_valid = 1'b1; step_pc = p;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic branch(lane_mask_t tk, pc_t tgt, pc_t ft, pc_t rc);
        @(negedge clk);
        br_valid = 1'b1; br_taken = tk; br_target_pc = tgt;
        br_fallthru_pc = ft; br_reconv_pc = rc;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        cur_req = "R2";
        step(32'h1004);
        step(32'h1008);

        cur_req = "R3";
        branch(32'hFFFF_FFFF, 32'h2000, 32'h100C, 32'h2FFF);
        cur_req = "R4";
        branch(32'h0000_0000, 32'h9000, 32'h2004, 32'h2FFF);

        cur_req = "R5";
        branch(32'h0000_FFFF, 32'h3000, 32'h2008, 32'h2100);
        cur_req = "R6";           // stall cycle: these requests must be ignored
        br_valid = 1'b1; br_taken = 32'hFFFF_FFFF; br_target_pc = 32'h7777;
        step_valid = 1'b1; step_pc = 32'h6666;
        @(negedge clk);
        br_valid = 1'b0; step_valid = 1'b0;
        idle(1);

        cur_req = "R7";
        step(32'h200C);
        step(32'h2100);           // reaches join: pop
        cur_req = "R11";          // branch and step during the pop cycle
        br_valid = 1'b1; br_taken = '0; br_fallthru_pc = 32'h8888;
        step_valid = 1'b1; step_pc = 32'h8880;
        @(negedge clk);
        br_valid = 1'b0; step_valid = 1'b0;
        idle(1);

        cur_req = "R3";           // inactive lanes' taken bits ignored
        branch(32'hFFFF_0000 | 32'h0000_FFFF, 32'h3010, 32'h3004, 32'h3FFF);
        cur_req = "R9";
        branch(32'h00FF_00FF, 32'h3200, 32'h3014, 32'h3100);
        idle(1);
        step(32'h3100);
        idle(2);
        step(32'h3100);
        idle(2);
        cur_req = "R8";
        step(32'h2100);
        idle(3);

        cur_req = "R10";
        branch(32'h0000_FFFF, 32'h4800, 32'h4000, 32'h5000); idle(1);
        branch(32'h00FF_00FF, 32'h4810, 32'h4010, 32'h5001); idle(1);
        branch(32'h0F0F_0F0F, 32'h4820, 32'h4020, 32'h5002); idle(1);
        branch(32'h3333_3333, 32'h4830, 32'h4030, 32'h5003); idle(1);
        branch(32'h5555_5555, 32'h4840, 32'h4040, 32'h5004); idle(2);
        step(32'h5004); idle(2);
        step(32'h5003); idle(2);
        step(32'h5003); idle(3);

        cur_req = "R1";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule